// File: doc/BRIEF.md
# Sub-Pixel Edge Placement Generator

This block produces the fast per-pixel clocks for a CCD readout path. It runs from a clock at 48 times the pixel rate. A phase counter splits each pixel period into 48 edge positions. Configuration inputs place the rising and falling edges of a reset gate pulse and of two horizontal clocks. They also set the positions of two sample strobes and the phase of the output data clock. The second horizontal phase of each pair is always the complement of the first, so the outputs drive either a 2-phase or a 4-phase horizontal register.

Each edge setting is a 6-bit word in quadrant form. The upper two bits pick one of four 12-position quadrants and the lower four bits pick an offset inside that quadrant. The block decodes these words itself. An offset larger than 11 is clamped, and the fault is latched in a sticky flag. All settings are captured into shadow registers only at the start of a pixel period, so a change made mid-period cannot cut a pulse short. A blanking input, together with a configured mask bit, can park the horizontal clocks. A data-ready pulse reports samples whose conversion result is due after a configurable number of pixels.

A two-state sequencer controls the phase counter. `PS_PRIME` is entered on reset. It captures the first set of configuration inputs and holds every output, then makes the transition prime-to-run into `PS_RUN`. In `PS_RUN` the counter steps once per fast clock. The run-wrap transition from position 47 to position 0 is also the moment the shadow registers reload. The run state stays in `PS_RUN` until reset.

Top module: `sub_pixel_edge_gen`

## Requirements
- R1: After the priming cycle, `pix_phase` steps by one per clock from 0 to 47 and then returns to 0. Every other output, registered, shows the value that belongs to the position `pix_phase` held one clock earlier.
- R2: An edge word maps to position bits[5:4] × 12 + bits[3:0]. Quadrant 0 covers positions 0–11, quadrant 1 covers 12–23, quadrant 2 covers 24–35 and quadrant 3 covers 36–47.
- R3: A word whose bits[3:0] are 12–15 is treated as offset 11 of its quadrant. When such a word is captured, `cfg_err` goes to 1 and stays at 1 until reset.
- R4: `rg_o`, `h1_o` and `h3_o` are high at positions p where (p − rise) mod 48 < (fall − rise) mod 48. They are therefore constantly low when rise equals fall. Setting the channel's inversion input to 1 complements the result.
- R5: `h2_o` is always the complement of `h1_o`, and `h4_o` is always the complement of `h3_o`.
- R6: During reset every output is 0 except `h2_o` and `h4_o`, which are 1. The shadow settings start at: reset gate rising at 0 and falling at 12, both horizontal clocks rising at 0 and falling at 24, first sample at 28, second sample at 0, data phase at 0, no inversion, mask 0 and fixed-clock mode off.
- R7: Configuration inputs are captured in the priming cycle and then on the clock where the counter goes from 47 to 0. A change made at any other time does not show at the outputs before the next position 0.
- R8: `samp_a_stb` and `samp_b_stb` are single-cycle pulses. Each fires for the position equal to its configured sample position.
- R9: With `cfg_dclk_fixed` = 0, `dclk_o` is high for the 24 positions starting at the data phase. With `cfg_dclk_fixed` = 1 it is high for positions 24–47, the inverse of a pixel clock that is high for positions 0–23, whatever the data phase is set to.
- R10: While `blank_in` is 1 and the captured mask bit is 1, `h1_o` and `h3_o` are 0 and `h2_o` and `h4_o` are 1. A captured mask of 0 leaves the horizontal clocks unaffected by `blank_in`.
- R11: At each data-phase position the block records whether a second-sample position occurred since the previous data-phase position, counting one that falls at that same position. `data_rdy` pulses at a data-phase position when the record made PIPE_PIX data-phase positions earlier was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rg_rise | input | 6 | Reset gate rising edge, quadrant form |
| cfg_rg_fall | input | 6 | Reset gate falling edge, quadrant form |
| cfg_rg_inv | input | 1 | Reset gate inversion |
| cfg_h1_rise | input | 6 | First horizontal clock rising edge |
| cfg_h1_fall | input | 6 | First horizontal clock falling edge |
| cfg_h1_inv | input | 1 | First horizontal clock inversion |
| cfg_h3_rise | input | 6 | Second horizontal clock rising edge |
| cfg_h3_fall | input | 6 | Second horizontal clock falling edge |
| cfg_h3_inv | input | 1 | Second horizontal clock inversion |
| cfg_samp_a | input | 6 | First sample strobe position |
| cfg_samp_b | input | 6 | Second sample strobe position |
| cfg_data_phase | input | 6 | Output data phase position |
| cfg_dclk_fixed | input | 1 | Data clock pinned to inverse pixel clock |
| cfg_blank_mask | input | 1 | Park horizontal clocks during blanking |
| blank_in | input | 1 | Blanking request, live |
| pix_phase | output | 6 | Current edge position 0–47 |
| rg_o | output | 1 | Reset gate pulse |
| h1_o | output | 1 | Horizontal clock phase 1 |
| h2_o | output | 1 | Complement of phase 1 |
| h3_o | output | 1 | Horizontal clock phase 3 |
| h4_o | output | 1 | Complement of phase 3 |
| samp_a_stb | output | 1 | First sample strobe |
| samp_b_stb | output | 1 | Second sample strobe |
| dclk_o | output | 1 | Output data clock |
| data_rdy | output | 1 | Delayed sample-ready pulse |
| cfg_err | output | 1 | Sticky invalid-offset flag |

## Verification
The second-sample position and the data-phase position can land in the same clock. In that case R11 says the sample taken in that cycle counts toward the record made in that same cycle, rather than the next one. The bench sets both positions to one value and checks that `data_rdy` keeps pulsing once per pixel, each time at that shared position. It then moves the sample one position past the data phase and checks the pulse again, now one pixel later. The per-clock reference model judges every cycle of both cases.

// File: rtl/spe_pkg.sv
package spe_pkg;

    // Slot numbers of the edge words inside the decoded edge array
    localparam int IX_RG_R = 0;
    localparam int IX_RG_F = 1;
    localparam int IX_H1_R = 2;
    localparam int IX_H1_F = 3;
    localparam int IX_H3_R = 4;
    localparam int IX_H3_F = 5;
    localparam int IX_SA   = 6;
    localparam int IX_SB   = 7;
    localparam int IX_DP   = 8;
    localparam int NEDGE   = 9;
    localparam int NCHAN   = 3;

    typedef enum logic {
        PS_PRIME,
        PS_RUN
    } phase_state_e;

    // Power-on position of each edge slot, as a fraction of the period
    function automatic int dflt_pos(input int slot, input int npos);
        case (slot)
            IX_RG_F:          return npos / 4;
            IX_H1_F, IX_H3_F: return npos / 2;
            IX_SA:            return (npos * 7) / 12;
            default:          return 0;
        endcase
    endfunction

endpackage

// File: rtl/spe_phase_seq.sv
module spe_phase_seq
    import spe_pkg::*;
#(
    parameter int NPOS = 48,
    parameter int PW   = $clog2(NPOS)
)(
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          run,
    output logic          load
);

    localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

    phase_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            PS_PRIME: begin
                load    = 1'b1;
                state_d = PS_RUN;
            end
            PS_RUN: begin
                run  = 1'b1;
                load = (phase == LAST);
            end
            default: state_d = PS_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < NPOS);

    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == LAST) |=> (phase == '0));

    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase != LAST) |=> (phase == $past(phase) + 1'b1));

    a_r7_prime_once: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

endmodule

// File: rtl/spe_edge_decode.sv
module spe_edge_decode #(
    parameter int QSZ = 12,
    parameter int EW  = 6,
    parameter int PW  = 6
)(
    input  logic [EW-1:0] raw,
    output logic [PW-1:0] pos,
    output logic          bad
);

    localparam int OW = EW - 2;

    logic [OW-1:0] off;

    assign bad = (raw[OW-1:0] > OW'(QSZ - 1));
    assign off = bad ? OW'(QSZ - 1) : raw[OW-1:0];
    assign pos = PW'(raw[EW-1:OW]) * PW'(QSZ) + PW'(off);

endmodule

// File: rtl/spe_window.sv
module spe_window #(
    parameter int PW = 6
)(
    input  logic [PW-1:0] phase,
    input  logic [PW-1:0] rise,
    input  logic [PW-1:0] fall,
    input  logic          inv,
    output logic          lvl
);

    logic base;

    always_comb begin
        if (rise < fall) begin
            base = (phase >= rise) && (phase < fall);
        end else if (rise > fall) begin
            base = (phase >= rise) || (phase < fall);
        end else begin
            base = 1'b0;
        end
        lvl = base ^ inv;
    end

endmodule

// File: rtl/sub_pixel_edge_gen.sv
module sub_pixel_edge_gen
    import spe_pkg::*;
#(
    parameter int QSZ      = 12,
    parameter int EW       = 6,
    parameter int PIPE_PIX = 3
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EW-1:0]              cfg_rg_rise,
    input  logic [EW-1:0]              cfg_rg_fall,
    input  logic                       cfg_rg_inv,
    input  logic [EW-1:0]              cfg_h1_rise,
    input  logic [EW-1:0]              cfg_h1_fall,
    input  logic                       cfg_h1_inv,
    input  logic [EW-1:0]              cfg_h3_rise,
    input  logic [EW-1:0]              cfg_h3_fall,
    input  logic                       cfg_h3_inv,
    input  logic [EW-1:0]              cfg_samp_a,
    input  logic [EW-1:0]              cfg_samp_b,
    input  logic [EW-1:0]              cfg_data_phase,
    input  logic                       cfg_dclk_fixed,
    input  logic                       cfg_blank_mask,
    input  logic                       blank_in,
    output logic [$clog2(4*QSZ)-1:0]   pix_phase,
    output logic                       rg_o,
    output logic                       h1_o,
    output logic                       h2_o,
    output logic                       h3_o,
    output logic                       h4_o,
    output logic                       samp_a_stb,
    output logic                       samp_b_stb,
    output logic                       dclk_o,
    output logic                       data_rdy,
    output logic                       cfg_err
);

    localparam int NPOS = 4 * QSZ;
    localparam int PW   = $clog2(NPOS);
    localparam int HALF = NPOS / 2;

    // ---------------- phase sequencer ----------------
    logic [PW-1:0] phase;
    logic          run;
    logic          load;

    spe_phase_seq #(.NPOS(NPOS), .PW(PW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .run   (run),
        .load  (load)
    );

    assign pix_phase = phase;

    // ---------------- live decode ----------------
    logic [EW-1:0] raw_e    [NEDGE];
    logic [PW-1:0] pos_live [NEDGE];
    logic          bad_live [NEDGE];
    logic          any_bad;

    assign raw_e[IX_RG_R] = cfg_rg_rise;
    assign raw_e[IX_RG_F] = cfg_rg_fall;
    assign raw_e[IX_H1_R] = cfg_h1_rise;
    assign raw_e[IX_H1_F] = cfg_h1_fall;
    assign raw_e[IX_H3_R] = cfg_h3_rise;
    assign raw_e[IX_H3_F] = cfg_h3_fall;
    assign raw_e[IX_SA]   = cfg_samp_a;
    assign raw_e[IX_SB]   = cfg_samp_b;
    assign raw_e[IX_DP]   = cfg_data_phase;

    for (genvar e = 0; e < NEDGE; e++) begin : g_dec
        spe_edge_decode #(.QSZ(QSZ), .EW(EW), .PW(PW)) u_dec (
            .raw (raw_e[e]),
            .pos (pos_live[e]),
            .bad (bad_live[e])
        );

        a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
            int'(pos_live[e]) < NPOS);
    end

    always_comb begin
        any_bad = 1'b0;
        for (int e = 0; e < NEDGE; e++) begin
            any_bad = any_bad | bad_live[e];
        end
    end

    // ---------------- shadow registers ----------------
    logic [PW-1:0] pos_sh [NEDGE];
    logic          inv_sh [NCHAN];
    logic          mask_sh;
    logic          fixed_sh;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NEDGE; e++) begin
                pos_sh[e] <= PW'(dflt_pos(e, NPOS));
            end
            for (int c = 0; c < NCHAN; c++) begin
                inv_sh[c] <= 1'b0;
            end
            mask_sh  <= 1'b0;
            fixed_sh <= 1'b0;
            err_q    <= 1'b0;
        end else if (load) begin
            for (int e = 0; e < NEDGE; e++) begin
                pos_sh[e] <= pos_live[e];
            end
            inv_sh[0] <= cfg_rg_inv;
            inv_sh[1] <= cfg_h1_inv;
            inv_sh[2] <= cfg_h3_inv;
            mask_sh   <= cfg_blank_mask;
            fixed_sh  <= cfg_dclk_fixed;
            err_q     <= err_q | any_bad;
        end
    end

    assign cfg_err = err_q;

    // ---------------- pulse windows ----------------
    logic [PW-1:0] win_rise [NCHAN];
    logic [PW-1:0] win_fall [NCHAN];
    logic          win_lvl  [NCHAN];

    assign win_rise[0] = pos_sh[IX_RG_R];
    assign win_fall[0] = pos_sh[IX_RG_F];
    assign win_rise[1] = pos_sh[IX_H1_R];
    assign win_fall[1] = pos_sh[IX_H1_F];
    assign win_rise[2] = pos_sh[IX_H3_R];
    assign win_fall[2] = pos_sh[IX_H3_F];

    for (genvar c = 0; c < NCHAN; c++) begin : g_win
        spe_window #(.PW(PW)) u_win (
            .phase (phase),
            .rise  (win_rise[c]),
            .fall  (win_fall[c]),
            .inv   (inv_sh[c]),
            .lvl   (win_lvl[c])
        );
    end

    // data clock: 24 positions from the data phase, or pinned
    logic [PW-1:0] dclk_rise, dclk_fall;
    logic          dclk_lvl;

    always_comb begin
        if (fixed_sh) begin
            dclk_rise = PW'(HALF);
            dclk_fall = '0;
        end else begin
            dclk_rise = pos_sh[IX_DP];
            dclk_fall = (int'(pos_sh[IX_DP]) >= HALF) ? pos_sh[IX_DP] - PW'(HALF)
                                                      : pos_sh[IX_DP] + PW'(HALF);
        end
    end

    spe_window #(.PW(PW)) u_dclk (
        .phase (phase),
        .rise  (dclk_rise),
        .fall  (dclk_fall),
        .inv   (1'b0),
        .lvl   (dclk_lvl)
    );

    // ---------------- sample / data pipeline ----------------
    logic                data_evt, samp_now, park;
    logic                seen_q;
    logic [PIPE_PIX-1:0] pipe_q, pipe_nxt;

    assign data_evt = (phase == pos_sh[IX_DP]);
    assign samp_now = (phase == pos_sh[IX_SB]);
    assign park     = blank_in && mask_sh;

    always_comb begin
        pipe_nxt[0] = seen_q | samp_now;
        for (int k = 1; k < PIPE_PIX; k++) begin
            pipe_nxt[k] = pipe_q[k-1];
        end
    end

    // ---------------- registered outputs ----------------
    logic rg_q, h1_q, h3_q, sa_q, sb_q, dclk_q, rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q   <= 1'b0;
            h1_q   <= 1'b0;
            h3_q   <= 1'b0;
            sa_q   <= 1'b0;
            sb_q   <= 1'b0;
            dclk_q <= 1'b0;
            rdy_q  <= 1'b0;
            seen_q <= 1'b0;
            pipe_q <= '0;
        end else if (run) begin
            rg_q   <= win_lvl[0];
            h1_q   <= park ? 1'b0 : win_lvl[1];
            h3_q   <= park ? 1'b0 : win_lvl[2];
            sa_q   <= (phase == pos_sh[IX_SA]);
            sb_q   <= samp_now;
            dclk_q <= dclk_lvl;
            if (data_evt) begin
                rdy_q  <= pipe_q[PIPE_PIX-1];
                pipe_q <= pipe_nxt;
                seen_q <= 1'b0;
            end else begin
                rdy_q  <= 1'b0;
                seen_q <= seen_q | samp_now;
            end
        end
    end

    assign rg_o       = rg_q;
    assign h1_o       = h1_q;
    assign h2_o       = ~h1_q;
    assign h3_o       = h3_q;
    assign h4_o       = ~h3_q;
    assign samp_a_stb = sa_q;
    assign samp_b_stb = sb_q;
    assign dclk_o     = dclk_q;
    assign data_rdy   = rdy_q;

    // ---------------- assertions ----------------
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r8_samp_a_single: assert property (@(posedge clk) disable iff (!rst_n)
        samp_a_stb |=> !samp_a_stb);

    a_r8_samp_b_single: assert property (@(posedge clk) disable iff (!rst_n)
        samp_b_stb |=> !samp_b_stb);

    a_r10_blank_park: assert property (@(posedge clk) disable iff (!rst_n)
        (run && blank_in && mask_sh) |=> (!h1_o && !h3_o && h2_o && h4_o));

    a_r11_rdy_at_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> ($past(pix_phase) == $past(pos_sh[IX_DP])));

endmodule

// File: tb/tb_sub_pixel_edge_gen.sv
`timescale 1ns/1ps
module tb_sub_pixel_edge_gen;

    localparam int P    = 3;
    localparam int NPOS = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] rg_r, rg_f, h1_r, h1_f, h3_r, h3_f, sa, sb, dp;
    logic rg_i, h1_i, h3_i, fixed, mask, blank;

    logic [5:0] pix_phase;
    logic rg_o, h1_o, h2_o, h3_o, h4_o, sa_o, sb_o, dclk_o, rdy_o, err_o;

    always #5 clk = ~clk;

    sub_pixel_edge_gen #(.QSZ(12), .EW(6), .PIPE_PIX(P)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rg_rise(rg_r), .cfg_rg_fall(rg_f), .cfg_rg_inv(rg_i),
        .cfg_h1_rise(h1_r), .cfg_h1_fall(h1_f), .cfg_h1_inv(h1_i),
        .cfg_h3_rise(h3_r), .cfg_h3_fall(h3_f), .cfg_h3_inv(h3_i),
        .cfg_samp_a(sa), .cfg_samp_b(sb), .cfg_data_phase(dp),
        .cfg_dclk_fixed(fixed), .cfg_blank_mask(mask), .blank_in(blank),
        .pix_phase(pix_phase), .rg_o(rg_o), .h1_o(h1_o), .h2_o(h2_o),
        .h3_o(h3_o), .h4_o(h4_o), .samp_a_stb(sa_o), .samp_b_stb(sb_o),
        .dclk_o(dclk_o), .data_rdy(rdy_o), .cfg_err(err_o)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string nm, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, nm, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_state, m_ph;
    int  s_pos [9];
    int  s_inv [3];
    int  s_mask, s_fix;
    int  e_rg, e_h1, e_h3, e_sa, e_sb, e_dclk, e_rdy, e_err;
    bit  m_seen;
    bit  m_q [$];
    int  rdy_count;

    function automatic int qdec(input logic [5:0] w);
        int off = int'(w[3:0]);
        if (off > 11) off = 11;
        return int'(w[5:4]) * 12 + off;
    endfunction

    function automatic bit qbad(input logic [5:0] w);
        return w[3:0] > 4'd11;
    endfunction

    function automatic int inwin(input int p, input int r, input int f);
        return (((p - r + NPOS) % NPOS) < ((f - r + NPOS) % NPOS)) ? 1 : 0;
    endfunction

    task automatic m_load();
        logic [5:0] w [9];
        w[0] = rg_r; w[1] = rg_f; w[2] = h1_r; w[3] = h1_f;
        w[4] = h3_r; w[5] = h3_f; w[6] = sa;   w[7] = sb; w[8] = dp;
        for (int i = 0; i < 9; i++) begin
            s_pos[i] = qdec(w[i]);
            if (qbad(w[i])) e_err = 1;
        end
        s_inv[0] = rg_i; s_inv[1] = h1_i; s_inv[2] = h3_i;
        s_mask = mask; s_fix = fixed;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_ph = 0;
            s_pos[0] = 0; s_pos[1] = 12; s_pos[2] = 0; s_pos[3] = 24;
            s_pos[4] = 0; s_pos[5] = 24; s_pos[6] = 28; s_pos[7] = 0; s_pos[8] = 0;
            for (int c = 0; c < 3; c++) s_inv[c] = 0;
            s_mask = 0; s_fix = 0;
            e_rg = 0; e_h1 = 0; e_h3 = 0; e_sa = 0; e_sb = 0;
            e_dclk = 0; e_rdy = 0; e_err = 0;
            m_seen = 0; m_q.delete();
        end else if (m_state == 0) begin
            m_load();
            m_state = 1;
        end else begin
            bit now_b;
            e_rg = inwin(m_ph, s_pos[0], s_pos[1]) ^ s_inv[0];
            e_h1 = (blank && s_mask) ? 0 : (inwin(m_ph, s_pos[2], s_pos[3]) ^ s_inv[1]);
            e_h3 = (blank && s_mask) ? 0 : (inwin(m_ph, s_pos[4], s_pos[5]) ^ s_inv[2]);
            e_sa = (m_ph == s_pos[6]) ? 1 : 0;
            e_sb = (m_ph == s_pos[7]) ? 1 : 0;
            e_dclk = s_fix ? ((m_ph >= 24) ? 1 : 0)
                           : ((((m_ph - s_pos[8] + NPOS) % NPOS) < 24) ? 1 : 0);
            now_b = (m_ph == s_pos[7]);
            if (m_ph == s_pos[8]) begin
                m_q.push_back(m_seen | now_b);
                e_rdy = 0;
                if (m_q.size() > P) e_rdy = m_q.pop_front();
                m_seen = 0;
            end else begin
                e_rdy = 0;
                m_seen = m_seen | now_b;
            end
            if (m_ph == NPOS - 1) m_load();
            m_ph = (m_ph + 1) % NPOS;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "pix_phase", pix_phase, m_ph);
            chk("R4/R7", "rg_o", rg_o, e_rg);
            chk("R4/R10", "h1_o", h1_o, e_h1);
            chk("R4/R10", "h3_o", h3_o, e_h3);
            chk("R5", "h2_o", h2_o, !h1_o);
            chk("R5", "h4_o", h4_o, !h3_o);
            chk("R8", "samp_a_stb", sa_o, e_sa);
            chk("R8", "samp_b_stb", sb_o, e_sb);
            chk("R9", "dclk_o", dclk_o, e_dclk);
            chk("R11", "data_rdy", rdy_o, e_rdy);
            chk("R3", "cfg_err", err_o, e_err);
            if (rdy_o) rdy_count++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic periods(input int n);
        repeat (n * NPOS) @(negedge clk);
    endtask

    task automatic set_defaults();
        rg_r = 6'h00; rg_f = 6'h10; rg_i = 0;
        h1_r = 6'h00; h1_f = 6'h20; h1_i = 0;
        h3_r = 6'h00; h3_f = 6'h20; h3_i = 0;
        sa = 6'h24; sb = 6'h00; dp = 6'h00;
        fixed = 0; mask = 0; blank = 0;
    endtask

    bit done = 0;
    int wd = 0;

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired, got %0d cycles expected under 100000", wd);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        set_defaults();
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6", "rg_o reset", rg_o, 0);
        chk("R6", "h1_o reset", h1_o, 0);
        chk("R6", "h2_o reset", h2_o, 1);
        chk("R6", "h4_o reset", h4_o, 1);
        chk("R6", "cfg_err reset", err_o, 0);
        chk("R6", "pix_phase reset", pix_phase, 0);
        rst_n = 1'b1;
        periods(3);

        // R2/R4/R7: 4-phase with wrapping windows, changed mid-period
        repeat (20) @(negedge clk);
        rg_r = 6'h05; rg_f = 6'h21;
        h1_r = 6'h2A; h1_f = 6'h06;
        h3_r = 6'h10; h3_f = 6'h30; h3_i = 1;
        sa = 6'h3B; sb = 6'h13; dp = 6'h25;
        @(negedge clk);
        chk("R7", "rg_o before wrap", rg_o, e_rg);
        periods(3);

        // R3: invalid offset clamps to 11 and latches the flag
        h1_r = 6'h1E;
        periods(2);
        chk("R3", "cfg_err after bad word", err_o, 1);
        h1_r = 6'h1B;
        periods(2);
        chk("R3", "cfg_err stays set", err_o, 1);

        // R4: equal rise/fall, with and without inversion
        rg_r = 6'h18; rg_f = 6'h18; rg_i = 0;
        periods(2);
        rg_i = 1;
        periods(2);
        rg_i = 0;

        // R10: blanking with mask on, then mask off
        mask = 1;
        periods(1);
        repeat (10) @(negedge clk);
        blank = 1;
        repeat (30) @(negedge clk);
        @(negedge clk);
        chk("R10", "h1_o parked", h1_o, 0);
        chk("R10", "h4_o parked", h4_o, 1);
        blank = 0;
        mask = 0;
        periods(2);
        blank = 1;
        periods(2);
        blank = 0;

        // R9: fixed data clock mode
        fixed = 1; dp = 6'h07;
        periods(2);
        hi = 0;
        for (int i = 0; i < NPOS; i++) begin
            @(negedge clk);
            if (dclk_o) hi++;
        end
        chk("R9", "dclk high count fixed", hi, 24);
        fixed = 0;
        periods(2);

        // R11: second sample coincides with data phase, then one after it
        rdy_count = 0;
        sb = 6'h2B; dp = 6'h2B;
        periods(8);
        chk("R11", "data_rdy pulses seen", (rdy_count > 0) ? 1 : 0, 1);
        sb = 6'h30; dp = 6'h2B;
        periods(8);
        set_defaults();
        periods(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule